// File: doc/BRIEF.md
# Bus address region decoder

This block sits on a 32-bit processor bus and tells each access where it lands. The upper 16 address bits form a 64 KiB page index. From that index the block picks one of five targets: main RAM, boot ROM, the I/O register window, the bus-interface control page, or unmapped space. It drives a one-hot select for the chosen target. It gives a RAM write enable, and it flags reads that must return zero because nothing answers them.

Main RAM and boot ROM appear three times, in the segments starting at pages 0x0000, 0x8000 and 0xA000. The I/O window exists only at page 0x1F80. One control word sits at byte address 0xFFFE0130. Writing certain magic values there turns a write-protect flag on or off. While the flag is on, 32-bit stores to page 0x0000 are dropped and every other RAM store still goes through. The select outputs are combinational from the current bus inputs. The protect flag changes on the clock edge that ends a qualifying write.

Top module: `addr_region_decode`

## Requirements
- R1: The page is bus_addr[31:16]. Pages 0x0000–0x007F select RAM (sel_ram) for reads and writes of any size. So do the same offsets in segments 0x8000 and 0xA000 (pages 0x8000–0x807F and 0xA000–0xA07F). Size codes are 0 = byte, 1 = halfword, 2 = word.
- R2: Pages 0x1FC0–0x1FC7, 0x9FC0–0x9FC7 and 0xBFC0–0xBFC7 select ROM (sel_rom) on reads. A write to any of them drives every output of the access low.
- R3: Page 0x1F80 selects I/O (sel_io) for reads and writes of all sizes. Pages 0x9F80 and 0xBF80 are unmapped.
- R4: A word write anywhere in page 0xFFFE asserts sel_ctl. Any read or byte/halfword access in that page is treated as unmapped.
- R5: A word write to 0xFFFE0130 with data 0x00000800 or 0x00000804 sets ram_protected on that clock edge. Data 0x00000000 or 0x0001E988 clears it. Other data leaves it unchanged, and so do other addresses or sizes.
- R6: While ram_protected is 1, a word write to page 0x0000 keeps sel_ram high and holds ram_wr_en low. Byte and halfword writes there, and word writes to other RAM pages or mirrors, keep ram_wr_en high. A flag set in one cycle blocks a word write in the very next cycle.
- R7: An access to an unmapped page asserts sel_none. A read there also asserts read_zero. A write there leaves read_zero and ram_wr_en low.
- R8: With bus_valid low, all select outputs, ram_wr_en and read_zero are low.
- R9: Synchronous active-high reset clears ram_protected. Reset wins over a set write in the same cycle.
- R10: At most one of sel_ram, sel_rom, sel_io, sel_ctl, sel_none is high. On a valid read, exactly one is high.
- R11: ram_wr_en is high only together with sel_ram and a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| sel_ram | output | 1 | Main RAM or a RAM mirror selected |
| sel_rom | output | 1 | Boot ROM or a ROM mirror selected (reads only) |
| sel_io | output | 1 | I/O register window selected |
| sel_ctl | output | 1 | Bus-interface control page, word write |
| sel_none | output | 1 | Access falls in unmapped space |
| ram_wr_en | output | 1 | RAM store allowed to proceed |
| read_zero | output | 1 | Read data must be forced to zero |
| ram_protected | output | 1 | Current state of the RAM write-protect flag |

## Verification
Two things can meet across one clock edge: a control write that sets the protect flag, and a protected word store to page 0x0000. The bench issues the set write and then the store in the very next cycle. It expects the store to be blocked while sel_ram stays high. Reset and a set write can also fall in the same cycle. The bench first raises the flag, then holds reset during a second set write, and expects the flag to read 0 afterwards.

// File: rtl/region_pkg.sv
package region_pkg;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_ROM  = 3'd2,
    RGN_IO   = 3'd3,
    RGN_CTL  = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

endpackage

// File: rtl/region_classify.sv
module region_classify
  import region_pkg::*;
#(
  parameter int                          PAGE_W    = 16,
  parameter int                          OFS_W     = 13,
  parameter int                          NUM_SEG   = 3,
  parameter logic [NUM_SEG*PAGE_W-1:0]   SEG_BASES = {16'hA000, 16'h8000, 16'h0000},
  parameter int                          RAM_PAGES = 128,
  parameter int                          ROM_BASE  = 'h1FC0,
  parameter int                          ROM_PAGES = 8,
  parameter logic [PAGE_W-1:0]           IO_PAGE   = 16'h1F80,
  parameter logic [PAGE_W-1:0]           CTL_PAGE  = 16'hFFFE
) (
  input  logic [PAGE_W-1:0] page,
  output region_e           region,
  output logic              page_zero
);

  localparam int SEG_W = PAGE_W - OFS_W;
  localparam logic [OFS_W-1:0] RAM_LIM = OFS_W'(RAM_PAGES);
  localparam logic [OFS_W-1:0] ROM_LO  = OFS_W'(ROM_BASE);
  localparam logic [OFS_W-1:0] ROM_HI  = OFS_W'(ROM_BASE + ROM_PAGES);

  logic [NUM_SEG-1:0] seg_hit;
  logic [OFS_W-1:0]   ofs;
  logic               in_seg;
  logic               ram_ofs;
  logic               rom_ofs;

  assign ofs = page[OFS_W-1:0];

  // one comparator per mirror segment
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam logic [PAGE_W-1:0] BASE = SEG_BASES[s*PAGE_W +: PAGE_W];
    localparam logic [SEG_W-1:0]  TOPB = BASE[PAGE_W-1:OFS_W];
    assign seg_hit[s] = (page[PAGE_W-1:OFS_W] == TOPB);
  end

  assign in_seg  = |seg_hit;
  assign ram_ofs = (ofs < RAM_LIM);
  assign rom_ofs = (ofs >= ROM_LO) && (ofs < ROM_HI);

  always_comb begin
    if (page == IO_PAGE)           region = RGN_IO;
    else if (page == CTL_PAGE)     region = RGN_CTL;
    else if (in_seg && ram_ofs)    region = RGN_RAM;
    else if (in_seg && rom_ofs)    region = RGN_ROM;
    else                           region = RGN_NONE;
  end

  assign page_zero = (page == '0);

endmodule

// File: rtl/protect_reg.sv
module protect_reg #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] SET_A  = 32'h0000_0800,
  parameter logic [DATA_W-1:0] SET_B  = 32'h0000_0804,
  parameter logic [DATA_W-1:0] CLR_A  = 32'h0000_0000,
  parameter logic [DATA_W-1:0] CLR_B  = 32'h0001_E988
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] wdata,
  output logic              flag
);

  logic is_set;
  logic is_clr;

  assign is_set = (wdata == SET_A) || (wdata == SET_B);
  assign is_clr = (wdata == CLR_A) || (wdata == CLR_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (upd) begin
      if (is_set)      flag <= 1'b1;
      else if (is_clr) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/access_gate.sv
module access_gate
  import region_pkg::*;
(
  input  logic    valid,
  input  logic    write,
  input  size_e   size,
  input  region_e region,
  input  logic    page_zero,
  input  logic    prot,
  output logic    sel_ram,
  output logic    sel_rom,
  output logic    sel_io,
  output logic    sel_ctl,
  output logic    sel_none,
  output logic    ram_wr_en
);

  logic is_word;
  logic blocked;

  assign is_word = (size == SZ_WORD);
  assign blocked = prot && page_zero && is_word;

  always_comb begin
    sel_ram   = 1'b0;
    sel_rom   = 1'b0;
    sel_io    = 1'b0;
    sel_ctl   = 1'b0;
    sel_none  = 1'b0;
    ram_wr_en = 1'b0;
    if (valid) begin
      unique case (region)
        RGN_RAM: begin
          sel_ram   = 1'b1;
          ram_wr_en = write && !blocked;
        end
        RGN_ROM: sel_rom = !write;
        RGN_IO:  sel_io  = 1'b1;
        RGN_CTL: begin
          if (write && is_word) sel_ctl  = 1'b1;
          else                  sel_none = 1'b1;
        end
        default: sel_none = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import region_pkg::*;
#(
  parameter int                        ADDR_W    = 32,
  parameter int                        DATA_W    = 32,
  parameter int                        PAGE_W    = 16,
  parameter int                        OFS_W     = 13,
  parameter int                        NUM_SEG   = 3,
  parameter logic [NUM_SEG*PAGE_W-1:0] SEG_BASES = {16'hA000, 16'h8000, 16'h0000},
  parameter int                        RAM_PAGES = 128,
  parameter int                        ROM_BASE  = 'h1FC0,
  parameter int                        ROM_PAGES = 8,
  parameter logic [PAGE_W-1:0]         IO_PAGE   = 16'h1F80,
  parameter logic [ADDR_W-1:0]         CTL_ADDR  = 32'hFFFE_0130,
  parameter logic [DATA_W-1:0]         SET_A     = 32'h0000_0800,
  parameter logic [DATA_W-1:0]         SET_B     = 32'h0000_0804,
  parameter logic [DATA_W-1:0]         CLR_A     = 32'h0000_0000,
  parameter logic [DATA_W-1:0]         CLR_B     = 32'h0001_E988
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_io,
  output logic              sel_ctl,
  output logic              sel_none,
  output logic              ram_wr_en,
  output logic              read_zero,
  output logic              ram_protected
);

  localparam logic [PAGE_W-1:0] CTL_PAGE = CTL_ADDR[ADDR_W-1:ADDR_W-PAGE_W];

  logic [PAGE_W-1:0] page;
  region_e           region;
  logic              page_zero;
  size_e             size;
  logic              ctl_upd;

  assign page = bus_addr[ADDR_W-1:ADDR_W-PAGE_W];
  assign size = size_e'(bus_size);

  region_classify #(
    .PAGE_W   (PAGE_W),
    .OFS_W    (OFS_W),
    .NUM_SEG  (NUM_SEG),
    .SEG_BASES(SEG_BASES),
    .RAM_PAGES(RAM_PAGES),
    .ROM_BASE (ROM_BASE),
    .ROM_PAGES(ROM_PAGES),
    .IO_PAGE  (IO_PAGE),
    .CTL_PAGE (CTL_PAGE)
  ) i_classify (
    .page     (page),
    .region   (region),
    .page_zero(page_zero)
  );

  // only a full-word store to the exact control word may touch the flag
  assign ctl_upd = bus_valid && bus_write && (size == SZ_WORD) && (bus_addr == CTL_ADDR);

  protect_reg #(
    .DATA_W(DATA_W),
    .SET_A (SET_A),
    .SET_B (SET_B),
    .CLR_A (CLR_A),
    .CLR_B (CLR_B)
  ) i_protect (
    .clk  (clk),
    .rst  (rst),
    .upd  (ctl_upd),
    .wdata(bus_wdata),
    .flag (ram_protected)
  );

  access_gate i_gate (
    .valid    (bus_valid),
    .write    (bus_write),
    .size     (size),
    .region   (region),
    .page_zero(page_zero),
    .prot     (ram_protected),
    .sel_ram  (sel_ram),
    .sel_rom  (sel_rom),
    .sel_io   (sel_io),
    .sel_ctl  (sel_ctl),
    .sel_none (sel_none),
    .ram_wr_en(ram_wr_en)
  );

  assign read_zero = sel_none && !bus_write;

endmodule

// File: rtl/addr_region_decode_chk.sv
module addr_region_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        sel_ram,
  input logic        sel_rom,
  input logic        sel_io,
  input logic        sel_ctl,
  input logic        sel_none,
  input logic        ram_wr_en,
  input logic        read_zero,
  input logic        ram_protected
);

  logic [4:0] sels;
  logic       ctl_word_wr;

  assign sels        = {sel_ram, sel_rom, sel_io, sel_ctl, sel_none};
  assign ctl_word_wr = bus_valid && bus_write && (bus_size == 2'd2) && (bus_addr == 32'hFFFE_0130);

  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sels));

  p_read_one_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |-> ($countones(sels) == 1));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (sels == 5'b0 && !ram_wr_en && !read_zero));

  p_wren_ram_r11: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> (sel_ram && bus_write));

  p_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    read_zero |-> (sel_none && !bus_write));

  p_rom_read_r2: assert property (@(posedge clk) disable iff (rst)
    sel_rom |-> !bus_write);

  p_ctl_word_r4: assert property (@(posedge clk) disable iff (rst)
    sel_ctl |-> (bus_write && bus_size == 2'd2 && bus_addr[31:16] == 16'hFFFE));

  p_block_r6: assert property (@(posedge clk) disable iff (rst)
    (ram_protected && bus_valid && bus_write && bus_size == 2'd2 && bus_addr[31:16] == 16'h0000)
      |-> (sel_ram && !ram_wr_en));

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_word_wr && (bus_wdata == 32'h800 || bus_wdata == 32'h804)) |=> ram_protected);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_word_wr && (bus_wdata == 32'h0 || bus_wdata == 32'h1E988)) |=> !ram_protected);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_word_wr |=> $stable(ram_protected));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> !ram_protected);

endmodule

bind addr_region_decode addr_region_decode_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_size     (bus_size),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .sel_ram      (sel_ram),
  .sel_rom      (sel_rom),
  .sel_io       (sel_io),
  .sel_ctl      (sel_ctl),
  .sel_none     (sel_none),
  .ram_wr_en    (ram_wr_en),
  .read_zero    (read_zero),
  .ram_protected(ram_protected)
);

// File: tb/test_addr_region_decode.sv
module test_addr_region_decode;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic sel_ram, sel_rom, sel_io, sel_ctl, sel_none, ram_wr_en, read_zero, ram_protected;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  addr_region_decode i_addr_region_decode (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_io(sel_io), .sel_ctl(sel_ctl),
    .sel_none(sel_none), .ram_wr_en(ram_wr_en), .read_zero(read_zero),
    .ram_protected(ram_protected)
  );

  // outputs packed as {ram, rom, io, ctl, none, wr_en, read_zero}
  function automatic logic [6:0] outs();
    return {sel_ram, sel_rom, sel_io, sel_ctl, sel_none, ram_wr_en, read_zero};
  endfunction

  // vector: req[77:74] addr[73:42] wr[41] size[40:39] data[38:7] exp[6:0]
  localparam int NV = 17;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  32'h0000_1234, 1'b0, 2'd2, 32'h0,     7'b1000000},
    {4'd1,  32'h007F_FFFC, 1'b1, 2'd0, 32'h5A,    7'b1000010},
    {4'd1,  32'h8000_0010, 1'b1, 2'd2, 32'h1,     7'b1000010},
    {4'd1,  32'hA07F_0000, 1'b0, 2'd1, 32'h0,     7'b1000000},
    {4'd7,  32'h0080_0000, 1'b0, 2'd2, 32'h0,     7'b0000101},
    {4'd2,  32'h1FC0_0000, 1'b0, 2'd0, 32'h0,     7'b0100000},
    {4'd2,  32'hBFC7_FFFF, 1'b0, 2'd0, 32'h0,     7'b0100000},
    {4'd2,  32'h9FC0_0000, 1'b1, 2'd2, 32'h7,     7'b0000000},
    {4'd7,  32'h1FC8_0000, 1'b0, 2'd2, 32'h0,     7'b0000101},
    {4'd3,  32'h1F80_1040, 1'b1, 2'd1, 32'h33,    7'b0010000},
    {4'd3,  32'h1F80_1814, 1'b0, 2'd2, 32'h0,     7'b0010000},
    {4'd3,  32'h9F80_0000, 1'b0, 2'd2, 32'h0,     7'b0000101},
    {4'd4,  32'hFFFE_0130, 1'b0, 2'd2, 32'h0,     7'b0000101},
    {4'd4,  32'hFFFE_0130, 1'b1, 2'd1, 32'h800,   7'b0000100},
    {4'd4,  32'hFFFE_0000, 1'b1, 2'd2, 32'h800,   7'b0001000},
    {4'd7,  32'h4000_0000, 1'b1, 2'd0, 32'h9,     7'b0000100},
    {4'd7,  32'h2000_0000, 1'b0, 2'd2, 32'h0,     7'b0000101}
  };

  function automatic string req_name(logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at the falling edge, settle, leave the rising edge to latch
  task automatic drive(logic v, logic w, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state (R8, R9)
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    @(negedge clk);
    check("R8", outs(), 7'b0000000);
    check1("R9", ram_protected, 1'b0);
    rst = 1'b0;

    // table walk, flag clear
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][41], VEC[i][40:39], VEC[i][73:42], VEC[i][38:7]);
      check(req_name(VEC[i][77:74]), outs(), VEC[i][6:0]);
    end
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    check1("R5", ram_protected, 1'b0);

    // R8: valid low on a RAM address
    drive(1'b0, 1'b1, 2'd2, 32'h0000_0100, 32'h1);
    check("R8", outs(), 7'b0000000);

    // R5 set with 0x804, then R6 blocking checks
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h804);
    check("R4", outs(), 7'b0001000);
    drive(1'b1, 1'b1, 2'd2, 32'h0000_0100, 32'h1);
    check1("R5", ram_protected, 1'b1);
    check("R6", outs(), 7'b1000000);
    drive(1'b1, 1'b1, 2'd0, 32'h0000_0100, 32'h1);
    check("R6", outs(), 7'b1000010);
    drive(1'b1, 1'b1, 2'd1, 32'h0000_0100, 32'h1);
    check("R6", outs(), 7'b1000010);
    drive(1'b1, 1'b1, 2'd2, 32'h8000_0100, 32'h1);
    check("R6", outs(), 7'b1000010);
    drive(1'b1, 1'b1, 2'd2, 32'h0001_0000, 32'h1);
    check("R11", outs(), 7'b1000010);
    drive(1'b1, 1'b0, 2'd2, 32'h0000_0100, 32'h0);
    check("R11", outs(), 7'b1000000);

    // R5 other data keeps flag
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h1234_5678);
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    check1("R5", ram_protected, 1'b1);

    // R5 clear with 0x1E988, store goes through again
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h1E988);
    drive(1'b1, 1'b1, 2'd2, 32'h0000_0000, 32'h1);
    check1("R5", ram_protected, 1'b0);
    check("R6", outs(), 7'b1000010);

    // R6 back-to-back: set with 0x800, blocked store next cycle
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h800);
    drive(1'b1, 1'b1, 2'd2, 32'h0000_FFFC, 32'h1);
    check("R6", outs(), 7'b1000000);

    // R5 clear with 0
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h0);
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    check1("R5", ram_protected, 1'b0);

    // R9 reset beats a set write in the same cycle
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h800);
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    check1("R5", ram_protected, 1'b1);
    rst = 1'b1;
    drive(1'b1, 1'b1, 2'd2, 32'hFFFE_0130, 32'h804);
    drive(1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    rst = 1'b0;
    check1("R9", ram_protected, 1'b0);

    finish_run();
  end

endmodule